// File: doc/BRIEF.md
# PRBS-23 Pattern Generator and Self-Synchronising Checker

This block is a per-channel built-in self-test pattern unit. Its transmit half runs a 23-stage linear feedback shift register on the polynomial x^23 + x^18 + 1. It emits ten fresh sequence bits per enabled clock as one parallel code-group word. Its receive half takes words from the receive path and seeds a reference history from the incoming bits. It then predicts each following word from that history. After a run of clean predictions it declares lock, and from then on it advances the reference on its own.

While locked, every received word that differs from the prediction in any bit adds one to a saturating error counter. Management logic reads this counter while a test runs. A burst of bad words inside a fixed window makes the checker fall out of lock and search again. Software can clear the counter alone, or restart the whole test. A restart reseeds the generator, drops lock and zeroes the count.

Top module: `prbs23_bist`

## Requirements
- R1: Each new sequence bit equals the XOR of the bits produced 23 and 18 steps earlier. The generator produces ten bits per word. The earliest bit of a word sits in bit 9 of gen_word. After reset or restart the register holds the all-ones seed, and the first word comes out on the clock edge after gen_en is sampled high.
- R2: While gen_en is low (and no restart), gen_word and the generator state hold their values. The sequence resumes where it stopped.
- R3: The generator register is never all zeros. A next state of zero is replaced by the seed, so the output never shows 23 zero bits in a row.
- R4: While unlocked, each valid word is shifted into a 23-bit history of the most recent received bits. The prediction for a word is the ten bits that the polynomial derives from that history. A word with rx_valid low changes neither the history, the lock state nor the count.
- R5: Lock is declared on the 16th consecutive valid word that equals its prediction, provided the history is not all zeros. A mismatch restarts the run. A stream of all-zero words never locks.
- R6: While locked, the reference advances by itself. Each valid word that differs from the prediction in one or more bits raises err_count by exactly one. The new value appears the cycle after the word is presented.
- R7: Lock windows are 16 valid words long, counted from the word after lock. Lock is dropped on the 8th mismatching word within one window. Seven mismatches per window keep lock.
- R8: No word presented while unlocked changes err_count.
- R9: err_count is 16 bits wide and saturates at all ones.
- R10: err_clear zeroes err_count and takes priority over a same-cycle increment. test_start also zeroes the count, drops lock, clears the history and reseeds the generator, which then restarts its sequence from the seed.
- R11: After reset, locked is 0, err_count is 0 and gen_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_start | input | 1 | Restart strobe: reseed, unlock, clear count |
| gen_en | input | 1 | Advance the generator by one word |
| gen_word | output | 10 | Generated code-group word, earliest bit in bit 9 |
| rx_valid | input | 1 | rx_word carries a received word |
| rx_word | input | 10 | Received code-group word, earliest bit in bit 9 |
| err_clear | input | 1 | Clear the error counter |
| locked | output | 1 | Checker is synchronised to the incoming stream |
| err_count | output | 16 | Saturating count of mismatching words while locked |

## Verification
The bench probes the lock boundary from a cleared history. The checker must still be unlocked after 15 words and locked after 19. A design that trusted a half-filled or all-zero history would lock early, and one with an off-by-one run counter would lock late or never. Seven errors per window must keep lock, and the 8th must drop it on exactly that word. A wrong window boundary or threshold shows up as a premature or missing drop. The bench also checks that words presented while unlocked or with rx_valid low leave the count alone, that a clear beats a same-cycle error, and that a narrow-counter copy stops at all ones rather than wrapping.

// File: rtl/prbs23_pkg.sv
package prbs23_pkg;
  localparam int unsigned PN_ORDER = 23;
  localparam int unsigned PN_TAP   = 18;
  localparam int unsigned WORD_W   = 10;

  typedef logic [PN_ORDER-1:0] pn_state_t;
  typedef logic [WORD_W-1:0]   pn_word_t;

  // Advance the register by one word; each step shifts left and appends
  // the feedback bit, so the oldest bit of a word lands in its top bit.
  function automatic pn_state_t pn_advance(pn_state_t s);
    pn_state_t t;
    t = s;
    for (int i = 0; i < WORD_W; i++)
      t = {t[PN_ORDER-2:0], t[PN_ORDER-1] ^ t[PN_TAP-1]};
    return t;
  endfunction

  // The word produced by one advance is the low part of the new state.
  function automatic pn_word_t pn_word_of(pn_state_t advanced);
    return advanced[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs23_pkg::*;
#(
  parameter pn_state_t SEED = '1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     en,
  output pn_word_t word
);
  pn_state_t st;
  pn_state_t nxt;
  logic      nxt_zero;

  assign nxt      = pn_advance(st);
  assign nxt_zero = (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st   <= SEED;
      word <= '0;
    end else if (en) begin
      st   <= nxt_zero ? SEED : nxt;
      word <= pn_word_of(nxt);
    end
  end

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0); // R3
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$past(restart)) |-> $stable(word)); // R2
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs23_pkg::*;
#(
  parameter int unsigned LOCK_RUN = 16,
  parameter int unsigned LOSS_WIN = 16,
  parameter int unsigned LOSS_TH  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     rx_valid,
  input  pn_word_t rx_word,
  output logic     locked,
  output logic     word_bad
);
  localparam int unsigned RUN_W = (LOCK_RUN > 1) ? $clog2(LOCK_RUN) : 1;
  localparam int unsigned WIN_W = (LOSS_WIN > 1) ? $clog2(LOSS_WIN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(LOSS_WIN - 1);
  localparam logic [WIN_W-1:0] LOSS_LAST = WIN_W'(LOSS_TH - 1);

  pn_state_t        hist;
  pn_state_t        pred_st;
  logic             mismatch;
  logic             hist_live;
  logic             word_good;
  logic             lock_hit;
  logic             loss_hit;
  logic             win_end;
  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W-1:0] win_err;

  assign pred_st   = pn_advance(hist);
  assign mismatch  = (pn_word_of(pred_st) != rx_word);
  assign hist_live = (hist != '0);
  assign word_good = !mismatch && hist_live;
  assign word_bad  = locked && rx_valid && mismatch;
  assign lock_hit  = !locked && rx_valid && word_good && (run == RUN_LAST);
  assign loss_hit  = word_bad && (win_err == LOSS_LAST);
  assign win_end   = (win_cnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      hist    <= '0;
      locked  <= 1'b0;
      run     <= '0;
      win_cnt <= '0;
      win_err <= '0;
    end else if (rx_valid) begin
      if (!locked) begin
        hist <= {hist[PN_ORDER-WORD_W-1:0], rx_word};
        if (lock_hit) begin
          locked  <= 1'b1;
          run     <= '0;
          win_cnt <= '0;
          win_err <= '0;
        end else if (word_good) begin
          run <= run + 1'b1;
        end else begin
          run <= '0;
        end
      end else if (loss_hit) begin
        hist    <= pred_st;
        locked  <= 1'b0;
        run     <= '0;
        win_cnt <= '0;
        win_err <= '0;
      end else begin
        hist    <= pred_st;
        win_cnt <= win_end ? '0 : win_cnt + 1'b1;
        win_err <= win_end ? '0 : win_err + WIN_W'(word_bad);
      end
    end
  end

  AST_LOCK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(run) == RUN_LAST && $past(rx_valid))); // R5
  AST_LOSS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(restart)) |-> ($past(win_err) == LOSS_LAST)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rx_valid) && !$past(restart)) |-> ($stable(locked) && $stable(hist))); // R4
endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic full;
  assign full = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)      cnt <= '0;
    else if (inc && !full)  cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(cnt)) && !$past(clr)) |-> (&cnt)); // R9
endmodule

// File: rtl/prbs23_bist.sv
module prbs23_bist
  import prbs23_pkg::*;
#(
  parameter pn_state_t   SEED     = '1,
  parameter int unsigned LOCK_RUN = 16,
  parameter int unsigned LOSS_WIN = 16,
  parameter int unsigned LOSS_TH  = 8,
  parameter int unsigned CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_start,
  input  logic              gen_en,
  output logic [WORD_W-1:0] gen_word,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              err_clear,
  output logic              locked,
  output logic [CNT_W-1:0]  err_count
);
  logic word_bad;
  logic cnt_clr;

  assign cnt_clr = err_clear || test_start;

  prbs_gen #(.SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .restart(test_start), .en(gen_en), .word(gen_word)
  );

  prbs_chk #(.LOCK_RUN(LOCK_RUN), .LOSS_WIN(LOSS_WIN), .LOSS_TH(LOSS_TH)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(test_start), .rx_valid(rx_valid),
    .rx_word(rx_word), .locked(locked), .word_bad(word_bad)
  );

  err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(word_bad), .cnt(err_count)
  );

  AST_NO_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(locked) && !$past(cnt_clr)) |-> $stable(err_count)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr) |-> (err_count == '0)); // R10
endmodule

// File: tb/sim_prbs23_bist.sv
`timescale 1ns/1ps
module sim_prbs23_bist;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_start = 1'b0;
  logic        gen_en = 1'b0;
  logic [9:0]  gen_word;
  logic        rx_valid = 1'b0;
  logic [9:0]  rx_word = '0;
  logic        err_clear = 1'b0;
  logic        locked, locked_n;
  logic [15:0] err_count;
  logic [3:0]  err_count_n;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int wpos = 0;
  bit done = 0;
  logic [22:0] gm;  // generator model, newest bit at [22]
  logic [22:0] rm;  // receive stream model, newest bit at [22]

  always #2.5 clk = ~clk;

  prbs23_bist u0 (
    .clk(clk), .rst_n(rst_n), .test_start(test_start), .gen_en(gen_en),
    .gen_word(gen_word), .rx_valid(rx_valid), .rx_word(rx_word),
    .err_clear(err_clear), .locked(locked), .err_count(err_count)
  );

  prbs23_bist #(.CNT_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .test_start(test_start), .gen_en(1'b0),
    .gen_word(), .rx_valid(rx_valid), .rx_word(rx_word),
    .err_clear(err_clear), .locked(locked_n), .err_count(err_count_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bit n is bit n-23 XOR bit n-18; in this view those sit at [0] and [5].
  task automatic model_word(ref logic [22:0] r, output logic [9:0] w);
    logic nb;
    w = '0;
    for (int i = 0; i < 10; i++) begin
      nb = r[0] ^ r[5];
      r  = {nb, r[22:1]};
      w  = {w[8:0], nb};
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [9:0] w, input logic v);
    rx_word = w; rx_valid = v;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic send_clean();
    logic [9:0] w;
    model_word(rm, w);
    send(w, 1'b1);
  endtask

  task automatic send_bad();
    logic [9:0] w;
    model_word(rm, w);
    send(w ^ 10'h001, 1'b1);
  endtask

  task automatic t_reset();
    check(locked == 1'b0, "R11", "locked after reset", locked, 0);
    check(err_count == 0, "R11", "count after reset", err_count, 0);
    check(gen_word == 0, "R11", "gen_word after reset", gen_word, 0);
  endtask

  task automatic t_generator();
    logic [9:0] e;
    int zrun = 0;
    gm = '1;
    gen_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      model_word(gm, e);
      check(gen_word == e, "R1", "generator word", gen_word, e);
      zrun = (gen_word == 0) ? zrun + 1 : 0;
      check(zrun < 3, "R3", "zero word run", zrun, 0);
    end
    gen_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(gen_word == e, "R2", "word held while disabled", gen_word, e);
    end
    gen_en = 1'b1;
    tick();
    gen_en = 1'b0;
    model_word(gm, e);
    check(gen_word == e, "R2", "sequence resumes", gen_word, e);
  endtask

  task automatic t_zero_stream();
    for (int i = 0; i < 40; i++) send(10'h000, 1'b1);
    check(locked == 1'b0, "R5", "all-zero stream lock", locked, 0);
    check(err_count == 0, "R8", "count while unlocked", err_count, 0);
  endtask

  task automatic t_acquire(input logic [22:0] start);
    int lock_at = 0;
    test_start = 1'b1; tick(); test_start = 1'b0;
    rm = start;
    for (int i = 1; i <= 19; i++) begin
      send_clean();
      if (i == 15) check(locked == 1'b0, "R5", "locked too early", locked, 0);
      if (locked && lock_at == 0) lock_at = i;
    end
    check(locked == 1'b1, "R5", "lock by word 19", locked, 1);
    check(err_count == 0, "R8", "no count during acquisition", err_count, 0);
    exp_cnt = 0;
    wpos = (19 - lock_at) % 16;
  endtask

  task automatic align_window();
    while (wpos != 0) begin
      send_clean();
      wpos = (wpos + 1) % 16;
    end
  endtask

  task automatic t_window_keep();
    align_window();
    for (int w = 0; w < 3; w++) begin
      for (int i = 0; i < 16; i++) begin
        if (i < 7) begin
          send_bad();
          exp_cnt++;
          check(err_count == exp_cnt, "R6", "count after bad word", err_count, exp_cnt);
        end else begin
          send_clean();
        end
      end
      check(locked == 1'b1, "R7", "lock kept at 7 per window", locked, 1);
      check(err_count_n == ((exp_cnt > 15) ? 15 : exp_cnt), "R9",
            "narrow counter", err_count_n, (exp_cnt > 15) ? 15 : exp_cnt);
    end
    send_bad(); exp_cnt++;
    send_bad(); exp_cnt++;
    wpos = 2;
    check(err_count_n == 15, "R9", "narrow counter saturated", err_count_n, 15);
    check(err_count == exp_cnt, "R6", "wide counter", err_count, exp_cnt);
  endtask

  task automatic t_idle_words();
    for (int i = 0; i < 5; i++) send(10'h3FF, 1'b0);
    check(err_count == exp_cnt, "R4", "invalid words ignored", err_count, exp_cnt);
    check(locked == 1'b1, "R4", "lock kept over invalid words", locked, 1);
    for (int i = 0; i < 5; i++) begin
      send_clean();
      wpos = (wpos + 1) % 16;
    end
    check(err_count == exp_cnt, "R4", "reference not advanced by invalid", err_count, exp_cnt);
  endtask

  task automatic t_window_drop();
    align_window();
    for (int i = 1; i <= 8; i++) begin
      send_bad();
      exp_cnt++;
      if (i == 7) check(locked == 1'b1, "R7", "lock after 7 errors", locked, 1);
    end
    check(locked == 1'b0, "R7", "lock dropped on 8th error", locked, 0);
    check(err_count == exp_cnt, "R7", "8th error counted", err_count, exp_cnt);
    for (int i = 0; i < 5; i++) send_bad();
    check(err_count == exp_cnt, "R8", "unlocked errors ignored", err_count, exp_cnt);
  endtask

  task automatic t_clear_restart();
    logic [9:0] e;
    for (int i = 0; i < 25 && !locked; i++) send_clean();
    check(locked == 1'b1, "R5", "relock", locked, 1);
    err_clear = 1'b1;
    send_bad();
    err_clear = 1'b0;
    check(err_count == 0, "R10", "clear beats increment", err_count, 0);
    send_bad();
    check(err_count == 1, "R6", "count after clear", err_count, 1);
    gen_en = 1'b1; tick(); tick(); gen_en = 1'b0;
    test_start = 1'b1; tick(); test_start = 1'b0;
    check(err_count == 0, "R10", "restart clears count", err_count, 0);
    check(locked == 1'b0, "R10", "restart drops lock", locked, 0);
    check(gen_word == 0, "R10", "restart clears word", gen_word, 0);
    gm = '1;
    gen_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      model_word(gm, e);
      check(gen_word == e, "R10", "generator reseeded", gen_word, e);
    end
    gen_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_generator();
    t_zero_stream();
    t_acquire(23'h1A2B3C);
    t_window_keep();
    t_idle_words();
    t_window_drop();
    t_clear_restart();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end
endmodule